// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous single-port memory built around a two-stage command pipeline. The address and command are captured on one rising edge. The data beat for that command, whether a read or a write, falls on the second enabled rising edge after it. Because read and write beats share the same latency, the data bus can change direction on every cycle with no idle slot between transfers.

Each load cycle either opens a four-beat burst or deselects the block. An advance cycle steps the two low address bits in linear or interleaved order, and it reuses the direction captured when the burst was loaded. A clock-enable input freezes the whole pipeline. An asynchronous output enable only masks the bus drive.

The bidirectional data bus is split into an input word, an output word and a drive-enable flag. The address port is 18 bits wide. The storage holds `2**MEM_AW` words and is indexed by the low `MEM_AW` address bits, so that simulation stays small.

Top module: `zt_burst_sram`

## Requirements
- R1: A read command captured on enabled edge T sets dataOut to the stored word after enabled edge T+2, with dataOutEn high while outEnN is low. For a write command captured on edge T, dataIn is sampled at enabled edge T+2.
- R2: Reads and writes may alternate on consecutive cycles with no idle cycle. A read issued on the cycle directly after a write to the same address returns the newly written word.
- R3: While clkEnN is high, every input is ignored. Every pipeline stage, the burst state, the storage, dataOut and dataOutEn keep their values, and operation resumes unchanged once clkEnN returns low.
- R4: A load cycle (advLoad low) starts an operation only when chipEnN0 is low, chipEn1 is high and chipEnN2 is low. Any other combination starts nothing and ends the burst. Operations already in the pipeline still complete.
- R5: dataOutEn goes low after enabled edge T+2 when edge T captured a write or a no-operation cycle.
- R6: An advance cycle (advLoad high) during an open burst issues the next burst address. It uses the read/write direction captured at load and ignores rdWrN. An advance cycle with no open burst behaves as a deselect.
- R7: With burstInterleave low, the two low address bits of beat k (k = 0..3) equal the loaded low bits plus k, modulo 4. Further advances keep wrapping.
- R8: With burstInterleave high, the two low address bits of beat k equal the loaded low bits XOR k. The address bits above bit 1 never change within a burst.
- R9: The word has two 9-bit lanes. laneWrEnN[0] guards bits 8:0 and laneWrEnN[1] guards bits 17:9, and both are active low and sampled with the command. A disabled lane keeps its old contents.
- R10: outEnN high forces dataOutEn low at once. It leaves the pipeline undisturbed, so later beats appear normally.
- R11: While rstN is low, dataOutEn is low and no operation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEnN | input | 1 | Clock enable, active low; high stalls everything |
| chipEnN0 | input | 1 | Chip enable, active low |
| chipEn1 | input | 1 | Chip enable, active high |
| chipEnN2 | input | 1 | Chip enable, active low |
| advLoad | input | 1 | Low loads a new address, high advances the burst |
| rdWrN | input | 1 | High reads, low writes (sampled on load cycles) |
| burstInterleave | input | 1 | Static order select: high interleaved, low linear |
| laneWrEnN | input | 2 | Per-lane write enables, active low |
| addr | input | 18 | Word address |
| dataIn | input | 18 | Write data, sampled on the write beat |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dataOut | output | 18 | Read data |
| dataOutEn | output | 1 | High when the block drives the data bus |

## Verification
The bench builds the block with its default parameters: an 18-bit address port and `MEM_AW` = 6, which gives a 64-word store. That store is small enough for a full shadow copy in the bench, yet it still holds several complete four-word burst blocks. Both burst orders can therefore be checked from every starting offset, including wrapping within a block. Because the address port keeps its full width, the same runs also confirm that the upper address bits stay fixed through a burst.

// File: rtl/zt_pkg.sv
package zt_pkg;
  localparam int LANE_W    = 9;
  localparam int NUM_LANES = 2;
  localparam int WORD_W    = LANE_W * NUM_LANES;

  // Command held in each pipeline stage
  typedef struct packed {
    logic                 valid;
    logic                 write;
    logic [NUM_LANES-1:0] lanes;
  } zt_cmd_t;

  // Strobes from control to datapath for the beat at the current edge
  typedef struct packed {
    logic                 step;
    logic                 wrBeat;
    logic                 rdBeat;
    logic [NUM_LANES-1:0] laneWr;
  } zt_strobe_t;
endpackage

// File: rtl/zt_ctrl.sv
module zt_ctrl
  import zt_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEnN,
  input  logic                 chipEnN0,
  input  logic                 chipEn1,
  input  logic                 chipEnN2,
  input  logic                 advLoad,
  input  logic                 rdWrN,
  input  logic                 burstInterleave,
  input  logic [NUM_LANES-1:0] laneWrEnN,
  input  logic [ADDR_W-1:0]    addr,
  output zt_strobe_t           stb,
  output logic [ADDR_W-1:0]    beatAddr
);
  localparam int CNT_W = 2;

  logic step, selected;
  assign step     = !clkEnN;
  assign selected = !chipEnN0 && chipEn1 && !chipEnN2;

  // Burst state
  logic              burstAct, burstDir;
  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  burstCnt;

  // Pipeline stages
  zt_cmd_t           p1Cmd, p2Cmd;
  logic [ADDR_W-1:0] p1Addr, p2Addr;

  // Next-state
  zt_cmd_t           nCmd;
  logic [ADDR_W-1:0] nAddr, nBase;
  logic              nAct, nDir;
  logic [CNT_W-1:0]  nCnt, cntInc, lowBits;

  assign cntInc  = burstCnt + 2'd1;
  assign lowBits = burstInterleave ? (baseAddr[CNT_W-1:0] ^ cntInc)
                                   : (baseAddr[CNT_W-1:0] + cntInc);

  always_comb begin
    nCmd  = '0;
    nAddr = baseAddr;
    nBase = baseAddr;
    nAct  = burstAct;
    nDir  = burstDir;
    nCnt  = burstCnt;
    if (!advLoad) begin
      if (selected) begin
        nCmd.valid = 1'b1;
        nCmd.write = !rdWrN;
        nCmd.lanes = ~laneWrEnN;
        nAddr      = addr;
        nBase      = addr;
        nCnt       = '0;
        nAct       = 1'b1;
        nDir       = !rdWrN;
      end else begin
        nAct = 1'b0;
      end
    end else if (burstAct) begin
      nCmd.valid = 1'b1;
      nCmd.write = burstDir;
      nCmd.lanes = ~laneWrEnN;
      nCnt       = cntInc;
      nAddr      = {baseAddr[ADDR_W-1:CNT_W], lowBits};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstAct <= 1'b0;
      burstDir <= 1'b0;
      baseAddr <= '0;
      burstCnt <= '0;
      p1Cmd    <= '0;
      p2Cmd    <= '0;
      p1Addr   <= '0;
      p2Addr   <= '0;
    end else if (step) begin
      burstAct <= nAct;
      burstDir <= nDir;
      baseAddr <= nBase;
      burstCnt <= nCnt;
      p1Cmd    <= nCmd;
      p1Addr   <= nAddr;
      p2Cmd    <= p1Cmd;
      p2Addr   <= p1Addr;
    end
  end

  always_comb begin
    stb.step   = step;
    stb.wrBeat = p2Cmd.valid && p2Cmd.write;
    stb.rdBeat = p2Cmd.valid && !p2Cmd.write;
    stb.laneWr = p2Cmd.lanes;
  end
  assign beatAddr = p2Addr;

  // R4: an unselected load starts nothing
  a_r4_no_start_unselected: assert property (@(posedge clk) disable iff (!rstN)
    step && !advLoad && !selected |=> !p1Cmd.valid);

  // R6: advance in an open burst keeps the loaded direction
  a_r6_adv_keeps_dir: assert property (@(posedge clk) disable iff (!rstN)
    step && advLoad && burstAct |=> p1Cmd.valid && (p1Cmd.write == $past(burstDir)));

  // R6: advance with no open burst is a deselect
  a_r6_adv_idle_deselect: assert property (@(posedge clk) disable iff (!rstN)
    step && advLoad && !burstAct |=> !p1Cmd.valid);

  // R8: upper address bits fixed within a burst
  a_r8_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    step && advLoad && burstAct |=> p1Addr[ADDR_W-1:CNT_W] == $past(baseAddr[ADDR_W-1:CNT_W]));

  // R3: stall freezes the pipeline
  a_r3_pipe_hold: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(p1Cmd) && $stable(p2Cmd) && $stable(p1Addr) && $stable(burstCnt));
endmodule

// File: rtl/zt_datapath.sv
module zt_datapath
  import zt_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  zt_strobe_t        stb,
  input  logic [MEM_AW-1:0] beatAddr,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdDrive
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [WORD_W-1:0] rdWord;

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (stb.step && stb.wrBeat && stb.laneWr[g])
        laneMem[beatAddr] <= dataIn[g*LANE_W +: LANE_W];
    end
    assign rdWord[g*LANE_W +: LANE_W] = laneMem[beatAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDrive <= 1'b0;
      rdData  <= '0;
    end else if (stb.step) begin
      rdDrive <= stb.rdBeat;
      if (stb.rdBeat) rdData <= rdWord;
    end
  end

  // R1: a read beat drives the bus after the edge
  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rstN)
    stb.step && stb.rdBeat |=> rdDrive);

  // R5: a write or empty beat releases the bus
  a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
    stb.step && !stb.rdBeat |=> !rdDrive);

  // R3: stall holds the output register
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.step |=> $stable(rdData) && $stable(rdDrive));
endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int MEM_AW = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEnN,
  input  logic                 chipEnN0,
  input  logic                 chipEn1,
  input  logic                 chipEnN2,
  input  logic                 advLoad,
  input  logic                 rdWrN,
  input  logic                 burstInterleave,
  input  logic [NUM_LANES-1:0] laneWrEnN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    dataIn,
  input  logic                 outEnN,
  output logic [WORD_W-1:0]    dataOut,
  output logic                 dataOutEn
);
  zt_strobe_t        stb;
  logic [ADDR_W-1:0] beatAddr;
  logic              rdDrive;
  logic              unusedAddrHi;

  assign unusedAddrHi = ^beatAddr[ADDR_W-1:MEM_AW];

  zt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN),
    .chipEnN0(chipEnN0), .chipEn1(chipEn1), .chipEnN2(chipEnN2),
    .advLoad(advLoad), .rdWrN(rdWrN), .burstInterleave(burstInterleave),
    .laneWrEnN(laneWrEnN), .addr(addr), .stb(stb), .beatAddr(beatAddr)
  );

  zt_datapath #(.MEM_AW(MEM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .beatAddr(beatAddr[MEM_AW-1:0]),
    .dataIn(dataIn), .rdData(dataOut), .rdDrive(rdDrive)
  );

  assign dataOutEn = rdDrive && !outEnN;

  // R11: nothing driven in reset
  always_comb begin
    if (!rstN) a_r11_reset_quiet: assert (!rdDrive);
  end
endmodule

// File: tb/zt_burst_sram_tb.sv
module zt_burst_sram_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEnN = 1'b0, chipEnN0 = 1'b1, chipEn1 = 1'b0, chipEnN2 = 1'b1;
  logic        advLoad = 1'b0, rdWrN = 1'b1, burstInterleave = 1'b0, outEnN = 1'b0;
  logic [1:0]  laneWrEnN = 2'b11;
  logic [17:0] addr = '0, dataIn = '0;
  logic [17:0] dataOut;
  logic        dataOutEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  zt_burst_sram u_dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .chipEnN0(chipEnN0), .chipEn1(chipEn1),
    .chipEnN2(chipEnN2), .advLoad(advLoad), .rdWrN(rdWrN), .burstInterleave(burstInterleave),
    .laneWrEnN(laneWrEnN), .addr(addr), .dataIn(dataIn), .outEnN(outEnN),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  typedef struct packed {
    bit          v;
    bit          w;
    logic [17:0] a;
    logic [1:0]  ln;
    logic [17:0] wd;
  } op_t;

  typedef struct {
    bit          drv;
    logic [17:0] val;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          nChk = 0, nFail = 0;
  string       curReq = "R11";
  op_t         s1 = '0, s2 = '0;
  bit          bAct = 0, bDir = 0, expDrv = 0;
  logic [17:0] bBase = '0, expVal = '0;
  logic [1:0]  bCnt = '0;
  logic [17:0] mm [64];

  localparam logic [2:0] SEL = 3'b010;   // {chipEnN2, chipEn1, chipEnN0}
  localparam logic [2:0] OFF = 3'b011;

  // Driver: applies one cycle and pushes the expected bus state after its edge
  task automatic cyc(input bit ce, input bit adv, input bit rw, input logic [17:0] a,
                     input logic [1:0] ln, input logic [2:0] cs, input logic [17:0] wd);
    op_t nOp; bit nAct; bit nDir; logic [17:0] nBase; logic [1:0] nCnt; logic [1:0] lo;
    item_t it;
    @(negedge clk); #1;
    clkEnN = !ce; advLoad = adv; rdWrN = rw; addr = a; laneWrEnN = ~ln;
    {chipEnN2, chipEn1, chipEnN0} = cs; dataIn = s2.wd;
    nOp = '0; nAct = bAct; nDir = bDir; nBase = bBase; nCnt = bCnt;
    if (!adv) begin
      if (cs == SEL) begin
        nOp.v = 1; nOp.w = !rw; nOp.a = a; nOp.ln = ln; nOp.wd = wd;
        nAct = 1; nDir = !rw; nBase = a; nCnt = 2'd0;
      end else nAct = 0;
    end else if (bAct) begin
      nCnt = bCnt + 2'd1;
      lo = burstInterleave ? (bBase[1:0] ^ nCnt) : (bBase[1:0] + nCnt);
      nOp.v = 1; nOp.w = bDir; nOp.a = {bBase[17:2], lo}; nOp.ln = ln; nOp.wd = wd;
    end
    @(posedge clk);
    if (ce) begin
      if (s2.v && s2.w) begin
        if (s2.ln[0]) mm[s2.a[5:0]][8:0]  = s2.wd[8:0];
        if (s2.ln[1]) mm[s2.a[5:0]][17:9] = s2.wd[17:9];
      end
      expDrv = s2.v && !s2.w;
      if (expDrv) expVal = mm[s2.a[5:0]];
      s2 = s1; s1 = nOp; bAct = nAct; bDir = nDir; bBase = nBase; bCnt = nCnt;
    end
    it.drv = expDrv; it.val = expVal; it.tag = curReq;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [17:0] a, input logic [17:0] d, input logic [1:0] ln = 2'b11);
    cyc(1, 0, 0, a, ln, SEL, d);
  endtask
  task automatic rd(input logic [17:0] a);
    cyc(1, 0, 1, a, 2'b11, SEL, 18'h0);
  endtask
  task automatic adv(input logic [17:0] d = 18'h0, input bit rw = 1);
    cyc(1, 1, rw, 18'h0, 2'b11, SEL, d);
  endtask
  task automatic idle(input int n = 1);
    for (int i = 0; i < n; i++) cyc(1, 0, 1, 18'h0, 2'b00, OFF, 18'h0);
  endtask

  // Monitor: pops expectations and compares against the ports
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it; bit expEn;
      it = sb.pop_front();
      expEn = it.drv && !outEnN;
      nChk++;
      if (dataOutEn !== expEn || (expEn && dataOut !== it.val)) begin
        nFail++;
        $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
                 it.tag, dataOutEn, dataOut, expEn, it.val);
      end
    end
  end

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run still active, expected finished");
    finishRun();
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    nChk++;
    if (dataOutEn !== 1'b0) begin
      nFail++; $display("FAIL R11: en=%0b expected 0", dataOutEn);
    end
    rstN = 1'b1;

    curReq = "R1";
    wr(5, 18'h2A5A5); wr(7, 18'h13579); idle(2); rd(5); rd(7); idle(3);

    curReq = "R2";
    wr(10, 18'h11111); rd(10); wr(11, 18'h22222); rd(11); rd(10);
    wr(10, 18'h3C3C3); rd(10); idle(3);

    curReq = "R5";
    rd(5); wr(6, 18'h12345); rd(6); wr(6, 18'h0F0F0); idle(3);

    curReq = "R9";
    wr(20, 18'h3FFFF); wr(20, 18'h00000, 2'b01); wr(21, 18'h3FFFF); wr(21, 18'h00000, 2'b10);
    rd(20); rd(21); idle(3);

    curReq = "R7";
    burstInterleave = 1'b0;
    wr(18'h22, 18'h10000); adv(18'h10001, 0); adv(18'h10002, 0); adv(18'h10003, 0);
    rd(18'h22); adv(); adv(); adv(); idle(1);
    rd(18'h20); rd(18'h21); rd(18'h22); rd(18'h23); idle(1);
    rd(18'h21); adv(); adv(); adv(); adv(); adv(); idle(3);

    curReq = "R8";
    burstInterleave = 1'b1;
    wr(18'h3002D, 18'h20000); adv(18'h20001, 0); adv(18'h20002, 0); adv(18'h20003, 0);
    rd(18'h2C); rd(18'h2D); rd(18'h2E); rd(18'h2F);
    rd(18'h1002E); adv(); adv(); adv(); idle(3);
    burstInterleave = 1'b0;

    curReq = "R6";
    idle(1); cyc(1, 1, 0, 18'd5, 2'b11, SEL, 18'h0BEEF); idle(2); rd(5); idle(2);
    rd(18'h20); adv(18'h3FFFF, 0); adv(18'h3FFFF, 0); idle(3);
    rd(18'h20); rd(18'h21); idle(3);

    curReq = "R4";
    cyc(1, 0, 0, 18'd7, 2'b11, 3'b011, 18'h0);
    cyc(1, 0, 0, 18'd7, 2'b11, 3'b000, 18'h0);
    cyc(1, 0, 0, 18'd7, 2'b11, 3'b110, 18'h0);
    idle(2); rd(7); idle(3);
    rd(5); rd(7); cyc(1, 1, 1, 18'd0, 2'b11, 3'b011, 18'h0); idle(3);

    curReq = "R3";
    rd(10);
    cyc(0, 0, 0, 18'd10, 2'b11, SEL, 18'h0); cyc(0, 0, 0, 18'd10, 2'b11, SEL, 18'h0);
    idle(1);
    cyc(0, 0, 0, 18'd10, 2'b11, SEL, 18'h0);
    idle(2); rd(10); idle(3);
    wr(11, 18'h0AAAA); cyc(0, 1, 1, 18'd0, 2'b00, OFF, 18'h0); cyc(0, 1, 1, 18'd0, 2'b00, OFF, 18'h0);
    idle(2); rd(11); idle(3);

    curReq = "R10";
    rd(5); rd(10); outEnN = 1'b1; idle(1); outEnN = 1'b0; idle(1); idle(2);
    rd(5); rd(10); idle(1); outEnN = 1'b1; idle(1); outEnN = 1'b0; idle(2);

    @(negedge clk); @(negedge clk);
    finishRun();
  end
endmodule